// File: doc/BRIEF.md
# Predicated Five-Slot VLIW Execute Stage

This block is the execute stage of a very-long-instruction-word core. Each clock it takes one instruction word with five independent operation slots and issues all five together. It reads the operands and the predicate of every slot from a 128-entry, 32-bit general register file. A slot runs only when bit 0 of its predicate register is set. The results of the slots that run are written back at the next clock edge.

There are two families of operation. The first is plain two's-complement integer arithmetic and logic, which wraps on overflow. The second is a four-lane byte operation that clamps each unsigned lane to 0..255. Two registers are fixed constants, so any slot can be made unconditional or turned into a no-op through its predicate field alone. Every slot result that is written also appears on a registered write-back port. This port is the block's only output, and it is how the surrounding pipeline sees results.

Top module: `vliw_exec5`

## Requirements
- R1: Slot s occupies bits [31*s+30 : 31*s] of `instr_word`. Within a slot the fields are: opcode in [2:0], predicate register in [9:3], source A in [16:10], source B in [23:17], destination in [30:24]. All five slots issue in the same cycle. A slot that runs drives `wb_en[s]`, `wb_dst` and `wb_data` one clock after it is presented, and its destination register holds the result from that same edge.
- R2: Synchronous active-high `rst` clears all 128 registers and all write-back outputs to zero.
- R3: Register 0 always reads as 0 and register 1 always reads as 1. Writes that target either of them are dropped.
- R4: A slot runs only when bit 0 of its predicate register is 1. When that bit is 0, the slot changes no register and leaves `wb_en[s]` low. Predicate register 1 makes a slot unconditional, and predicate register 0 makes it a no-op.
- R5: Opcode 1 is A+B and opcode 2 is A-B, both in 32-bit two's complement that wraps. Opcode 3 is bitwise AND and opcode 4 is bitwise OR.
- R6: Opcode 5 adds the four byte lanes as unsigned values, and opcode 6 subtracts them. A lane that overflows gives 255 and a lane that underflows gives 0 (so 180+180 gives 255).
- R7: Every operand and predicate read in a cycle sees the register contents from before that cycle's writes.
- R8: When two running slots target the same register in one cycle, the slot with the higher index determines the value stored.
- R9: Opcode 0 (NOP), opcode 7 (reserved), and any word presented while `instr_valid` is low write nothing and leave `wb_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 155 | Five 31-bit operation slots |
| wb_en | output | 5 | Per-slot flag: the slot ran last cycle |
| wb_dst | output | 35 | Per-slot destination register, 7 bits per slot |
| wb_data | output | 160 | Per-slot result, 32 bits per slot |

## Verification
Within a single cycle, two things can collide: register write-back from several slots, and operand and predicate reads by other slots. The bench places both in one word in two ways. In the first, two running slots share a destination. In the second, one slot rewrites a register that another slot in the same word reads as an operand and that a third slot uses as its predicate. The result is judged by reading the register back in a later word and by the write-back port of the reading slot. The stored value must come from the higher slot. The reader must see the old value. The predicate must be evaluated on the old bit 0.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_NOP   = 3'd0;
  localparam logic [OPC_W-1:0] OPC_IADD  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_ISUB  = 3'd2;
  localparam logic [OPC_W-1:0] OPC_AND   = 3'd3;
  localparam logic [OPC_W-1:0] OPC_OR    = 3'd4;
  localparam logic [OPC_W-1:0] OPC_BADDS = 3'd5;
  localparam logic [OPC_W-1:0] OPC_BSUBS = 3'd6;
  localparam logic [OPC_W-1:0] OPC_RSVD  = 3'd7;
  localparam int RD_PER_SLOT = 3;
endpackage

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int NREG = 128,
  parameter int XLEN = 32,
  parameter int NRD  = 15,
  parameter int NWR  = 5,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NRD*RIDX-1:0]  rd_addr,
  output logic [NRD*XLEN-1:0]  rd_data,
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR*RIDX-1:0]  wr_addr,
  input  logic [NWR*XLEN-1:0]  wr_data
);
  logic [XLEN-1:0] mem [NREG];

  // later ports overwrite earlier ones: highest slot wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++) begin
        if (wr_en[w] && (wr_addr[w*RIDX +: RIDX] > RIDX'(1)))
          mem[wr_addr[w*RIDX +: RIDX]] <= wr_data[w*XLEN +: XLEN];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [RIDX-1:0] a;
    assign a = rd_addr[p*RIDX +: RIDX];
    always_comb begin
      if (a == RIDX'(0))      rd_data[p*XLEN +: XLEN] = '0;
      else if (a == RIDX'(1)) rd_data[p*XLEN +: XLEN] = XLEN'(1);
      else                    rd_data[p*XLEN +: XLEN] = mem[a];
    end
  end
endmodule

// File: rtl/vliw_byte_sat.sv
module vliw_byte_sat #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = XLEN / LANE_W
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] y
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [LANE_W:0] t;
    always_comb begin
      if (sub) begin
        t = {1'b0, a[l*LANE_W +: LANE_W]} - {1'b0, b[l*LANE_W +: LANE_W]};
        y[l*LANE_W +: LANE_W] = t[LANE_W] ? '0 : t[LANE_W-1:0];
      end else begin
        t = {1'b0, a[l*LANE_W +: LANE_W]} + {1'b0, b[l*LANE_W +: LANE_W]};
        y[l*LANE_W +: LANE_W] = t[LANE_W] ? '1 : t[LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vliw_slot_alu.sv
module vliw_slot_alu
  import vliw_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic             live,
  output logic [XLEN-1:0]  y
);
  logic [XLEN-1:0] media_y;

  vliw_byte_sat #(.XLEN(XLEN), .LANE_W(LANE_W)) u_media (
    .a(a), .b(b), .sub(opc == OPC_BSUBS), .y(media_y)
  );

  always_comb begin
    live = 1'b1;
    case (opc)
      OPC_IADD:             y = a + b;
      OPC_ISUB:             y = a - b;
      OPC_AND:              y = a & b;
      OPC_OR:               y = a | b;
      OPC_BADDS, OPC_BSUBS: y = media_y;
      default: begin
        y    = '0;
        live = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/vliw_exec5.sv
module vliw_exec5
  import vliw_pkg::*;
#(
  parameter int NSLOT  = 5,
  parameter int XLEN   = 32,
  parameter int NREG   = 128,
  parameter int LANE_W = 8,
  localparam int RIDX   = $clog2(NREG),
  localparam int SLOT_W = OPC_W + 4*RIDX,
  localparam int NRD    = NSLOT * RD_PER_SLOT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instr_valid,
  input  logic [NSLOT*SLOT_W-1:0] instr_word,
  output logic [NSLOT-1:0]        wb_en,
  output logic [NSLOT*RIDX-1:0]   wb_dst,
  output logic [NSLOT*XLEN-1:0]   wb_data
);
  logic [NRD*RIDX-1:0]    rd_addr;
  logic [NRD*XLEN-1:0]    rd_data;
  logic [NSLOT-1:0]       fire;
  logic [NSLOT-1:0]       pred_bit;
  logic [NSLOT*OPC_W-1:0] opc_flat;
  logic [NSLOT*RIDX-1:0]  srca_flat;
  logic [NSLOT*RIDX-1:0]  dst_flat;
  logic [NSLOT*XLEN-1:0]  a_flat;
  logic [NSLOT*XLEN-1:0]  b_flat;
  logic [NSLOT*XLEN-1:0]  y_flat;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [SLOT_W-1:0] fld;
    logic              live;
    assign fld = instr_word[s*SLOT_W +: SLOT_W];
    assign opc_flat[s*OPC_W +: OPC_W] = fld[OPC_W-1:0];
    assign rd_addr[(3*s+0)*RIDX +: RIDX] = fld[OPC_W +: RIDX];
    assign rd_addr[(3*s+1)*RIDX +: RIDX] = fld[OPC_W+RIDX +: RIDX];
    assign rd_addr[(3*s+2)*RIDX +: RIDX] = fld[OPC_W+2*RIDX +: RIDX];
    assign srca_flat[s*RIDX +: RIDX] = fld[OPC_W+RIDX +: RIDX];
    assign dst_flat[s*RIDX +: RIDX]  = fld[OPC_W+3*RIDX +: RIDX];
    assign pred_bit[s] = rd_data[(3*s+0)*XLEN];
    assign a_flat[s*XLEN +: XLEN] = rd_data[(3*s+1)*XLEN +: XLEN];
    assign b_flat[s*XLEN +: XLEN] = rd_data[(3*s+2)*XLEN +: XLEN];

    vliw_slot_alu #(.XLEN(XLEN), .LANE_W(LANE_W)) u_alu (
      .opc (opc_flat[s*OPC_W +: OPC_W]),
      .a   (a_flat[s*XLEN +: XLEN]),
      .b   (b_flat[s*XLEN +: XLEN]),
      .live(live),
      .y   (y_flat[s*XLEN +: XLEN])
    );
    assign fire[s] = instr_valid & live & pred_bit[s];
  end

  vliw_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD), .NWR(NSLOT)) u_rf (
    .clk(clk), .rst(rst),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(fire), .wr_addr(dst_flat), .wr_data(y_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= '0;
      wb_dst  <= '0;
      wb_data <= '0;
    end else begin
      wb_en   <= fire;
      wb_dst  <= dst_flat;
      wb_data <= y_flat;
    end
  end
endmodule

// File: rtl/vliw_exec5_chk.sv
module vliw_exec5_chk
  import vliw_pkg::*;
#(
  parameter int NSLOT  = 5,
  parameter int XLEN   = 32,
  parameter int NREG   = 128,
  parameter int LANE_W = 8,
  localparam int RIDX  = $clog2(NREG),
  localparam int NLANE = XLEN / LANE_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    instr_valid,
  input logic [NSLOT-1:0]        wb_en,
  input logic [NSLOT*XLEN-1:0]   wb_data,
  input logic [NSLOT-1:0]        pred_bit,
  input logic [NSLOT*OPC_W-1:0]  opc_flat,
  input logic [NSLOT*RIDX-1:0]   srca_flat,
  input logic [NSLOT*XLEN-1:0]   a_flat,
  input logic [NSLOT*XLEN-1:0]   b_flat
);
  // R9
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (wb_en == '0));

  for (genvar s = 0; s < NSLOT; s++) begin : g_s
    // R4
    pred_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && !pred_bit[s]) |=> !wb_en[s]);
    // R3
    zero_reg_read_chk: assert property (@(posedge clk) disable iff (rst)
      (srca_flat[s*RIDX +: RIDX] == RIDX'(0)) |-> (a_flat[s*XLEN +: XLEN] == '0));
    // R5
    iadd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && pred_bit[s] && opc_flat[s*OPC_W +: OPC_W] == OPC_IADD)
      |=> (wb_data[s*XLEN +: XLEN] == $past(a_flat[s*XLEN +: XLEN] + b_flat[s*XLEN +: XLEN])));
    for (genvar l = 0; l < NLANE; l++) begin : g_l
      // R6
      lane_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && pred_bit[s] && opc_flat[s*OPC_W +: OPC_W] == OPC_BADDS)
        |=> (wb_data[s*XLEN + l*LANE_W +: LANE_W] >= $past(a_flat[s*XLEN + l*LANE_W +: LANE_W])));
    end
  end
endmodule

bind vliw_exec5 vliw_exec5_chk #(
  .NSLOT(NSLOT), .XLEN(XLEN), .NREG(NREG), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid),
  .wb_en(wb_en), .wb_data(wb_data), .pred_bit(pred_bit),
  .opc_flat(opc_flat), .srca_flat(srca_flat),
  .a_flat(a_flat), .b_flat(b_flat)
);

// File: tb/sim_vliw_exec5.sv
module sim_vliw_exec5;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;
  localparam int SW = 31;
  localparam int W  = NS*SW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           instr_valid = 1'b0;
  logic [W-1:0]   instr_word = '0;
  logic [NS-1:0]  wb_en;
  logic [NS*7-1:0]  wb_dst;
  logic [NS*32-1:0] wb_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_exec5 u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  // opcode, a, b, expected
  localparam logic [98:0] VEC [8] = '{
    {3'd1, 32'h0000_0007, 32'h0000_0009, 32'h0000_0010},
    {3'd1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {3'd2, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
    {3'd3, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h00F0_1234},
    {3'd4, 32'hF000_0001, 32'h000F_0010, 32'hF00F_0011},
    {3'd5, 32'h0000_00B4, 32'h0000_00B4, 32'h0000_00FF},
    {3'd5, 32'hB4B4_1001, 32'hB401_FF02, 32'hFFB5_FF03},
    {3'd6, 32'h1080_05FF, 32'h207F_0601, 32'h0001_00FE}
  };

  function automatic logic [SW-1:0] slot(input logic [2:0] opc, input int p, input int a,
                                         input int b, input int d);
    return {7'(d), 7'(b), 7'(a), 7'(p), opc};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [W-1:0] w, input logic v = 1'b1);
    @(negedge clk);
    instr_valid = v;
    instr_word  = w;
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
    instr_word  = '0;
  endtask

  task automatic load(input int r, input logic [31:0] v);
    issue(W'(slot(3'd4, 1, 0, 0, r)));
    for (int i = 31; i >= 0; i--) begin
      issue(W'(slot(3'd1, 1, r, r, r)));
      if (v[i]) issue(W'(slot(3'd1, 1, r, 1, r)));
    end
  endtask

  task automatic rd(input int r, output logic [31:0] v);
    issue(W'(slot(3'd4, 1, r, 0, 127)));
    v = wb_data[31:0];
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [W-1:0] w;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    check("R2 wb_en at reset", 32'(wb_en), 32'h0);
    check("R2 wb_data at reset", wb_data[31:0], 32'h0);
    @(negedge clk); rst = 1'b0;
    rd(5, v);  check("R2 r5 cleared", v, 32'h0);

    // R5 R6 R1: table walk
    for (int i = 0; i < 8; i++) begin
      load(10, VEC[i][95:64]);
      load(11, VEC[i][63:32]);
      issue(W'(slot(VEC[i][98:96], 1, 10, 11, 12)));
      check("R1 wb_en slot0", 32'(wb_en[0]), 32'h1);
      check("R1 wb_dst slot0", 32'(wb_dst[6:0]), 32'd12);
      check((VEC[i][98:96] >= 3'd5) ? "R6 media result" : "R5 integer result",
            wb_data[31:0], VEC[i][31:0]);
      rd(12, v); check("R1 writeback stored", v, VEC[i][31:0]);
    end

    // R3: constant registers
    rd(1, v); check("R3 r1 reads one", v, 32'h1);
    issue(W'(slot(3'd1, 1, 1, 1, 0)));
    rd(0, v); check("R3 r0 write dropped", v, 32'h0);
    issue(W'(slot(3'd1, 1, 1, 1, 1)));
    rd(1, v); check("R3 r1 write dropped", v, 32'h1);

    // R4: predicates
    load(20, 32'h2); load(21, 32'h3); load(22, 32'h55);
    issue(W'(slot(3'd1, 20, 21, 21, 22)));
    check("R4 pred bit0 clear no wb_en", 32'(wb_en), 32'h0);
    rd(22, v); check("R4 pred clear keeps dest", v, 32'h55);
    issue(W'(slot(3'd1, 0, 21, 21, 22)));
    check("R4 pred r0 no wb_en", 32'(wb_en), 32'h0);
    rd(22, v); check("R4 pred r0 keeps dest", v, 32'h55);
    issue(W'(slot(3'd1, 21, 21, 21, 22)));
    rd(22, v); check("R4 pred odd executes", v, 32'h6);

    // R9: NOP, reserved, invalid word
    load(22, 32'h55);
    issue(W'(slot(3'd0, 1, 21, 21, 22)));
    check("R9 nop no wb_en", 32'(wb_en), 32'h0);
    issue(W'(slot(3'd7, 1, 21, 21, 22)));
    check("R9 reserved no wb_en", 32'(wb_en), 32'h0);
    issue(W'(slot(3'd1, 1, 21, 21, 22)), 1'b0);
    check("R9 invalid no wb_en", 32'(wb_en), 32'h0);
    rd(22, v); check("R9 dest untouched", v, 32'h55);

    // R8: same destination in one word
    w = '0;
    w[0*SW +: SW] = slot(3'd1, 1, 21, 21, 30);
    w[1*SW +: SW] = slot(3'd1, 0, 21, 21, 30);
    w[3*SW +: SW] = slot(3'd4, 1, 21, 0, 30);
    issue(w);
    rd(30, v); check("R8 higher slot wins", v, 32'h3);
    w[3*SW +: SW] = slot(3'd4, 20, 21, 0, 30);
    issue(w);
    rd(30, v); check("R8 disabled higher slot yields", v, 32'h6);

    // R7: reads see pre-write state
    load(40, 32'd10);
    w = '0;
    w[0*SW +: SW] = slot(3'd1, 1, 40, 1, 40);
    w[1*SW +: SW] = slot(3'd4, 1, 40, 0, 41);
    w[2*SW +: SW] = slot(3'd1, 40, 1, 1, 42);
    issue(w);
    check("R7 operand old value", wb_data[63:32], 32'd10);
    check("R7 predicate old value", 32'(wb_en), 32'h3);
    rd(40, v); check("R7 write landed", v, 32'd11);

    // R1: five slots at once
    w = '0;
    w[0*SW +: SW] = slot(3'd1, 1, 21, 21, 50);
    w[1*SW +: SW] = slot(3'd2, 1, 21, 1, 51);
    w[2*SW +: SW] = slot(3'd3, 1, 21, 20, 52);
    w[3*SW +: SW] = slot(3'd4, 1, 20, 1, 53);
    w[4*SW +: SW] = slot(3'd5, 1, 21, 21, 54);
    issue(w);
    check("R1 all slots fire", 32'(wb_en), 32'h1F);
    check("R1 slot0", wb_data[31:0], 32'd6);
    check("R1 slot1", wb_data[63:32], 32'd2);
    check("R1 slot2", wb_data[95:64], 32'd2);
    check("R1 slot3", wb_data[127:96], 32'd3);
    check("R1 slot4", wb_data[159:128], 32'd6);
    check("R1 slot4 dst", 32'(wb_dst[34:28]), 32'd54);
    rd(53, v); check("R1 slot3 stored", v, 32'd3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule